// File: doc/BRIEF.md
# Bridge ADC Readout Controller

This block is the host-side reader for an 18-bit sigma-delta converter used with bridge sensors. The converter has one shared output line that first signals "result ready" by falling from its idle high level, and then carries the serial result bits. The block watches that line through a two-flop synchronizer. When it sees a ready indication it generates the serial clock, shifts in 18 bits with the most significant bit first, and issues one extra clock pulse so that the converter drives the line high again.

The signed result appears on a parallel bus together with a one-cycle valid strobe. A full-scale flag marks the two saturated codes. The block also registers two configuration inputs onto the converter's power and conversion-rate pins. The serial clock half-period is a parameter counted in system clocks, so the converter's minimum phase width can be met at any system clock rate.

Top module: `bridge_adc_rx`

## Requirements
- R1: After reset `sclk_o`, `result_valid_o`, `full_scale_o`, `pwr_o` and `rate_o` are low, and `result_o` is zero.
- R2: A read starts only when the controller is idle, powered, and sees the synchronized shared line fall after it has been seen high while idle. A line that stays low after a read, or low after power-up, starts no read.
- R3: Each read issues exactly 19 rising edges on `sclk_o`. The first 18 deliver data, and the bit delivered after the first rising edge lands in `result_o[17]`, down to `result_o[0]` from the 18th. The 19th edge is the re-arm pulse.
- R4: Every high phase and every low phase of `sclk_o` lasts at least `HALF_CLKS` system clocks (default 2, which is 100 ns at 20 MHz).
- R5: `result_valid_o` is a single-cycle pulse raised after the low phase of the re-arm pulse. `result_o` holds its value until the next read completes.
- R6: `full_scale_o` is high in the valid cycle exactly when the result is 0x1FFFF (positive full scale) or 0x20000 (negative full scale), and low at all other times.
- R7: `pwr_o` follows `run_en_i` one clock later (high = converter running). While it is low, no read starts.
- R8: `rate_o` follows `fast_rate_i` one clock later (low = 10 samples/s, high = 80 samples/s).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_dat_i | input | 1 | Shared ready/data line from converter |
| run_en_i | input | 1 | Configuration: converter running when high |
| fast_rate_i | input | 1 | Configuration: high selects 80 samples/s |
| sclk_o | output | 1 | Serial clock to converter |
| pwr_o | output | 1 | Converter power control |
| rate_o | output | 1 | Converter rate select |
| result_o | output | 18 | Last signed result, two's complement |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| full_scale_o | output | 1 | Result is a saturated code, qualified by valid |

## Verification
The full-scale flag and the valid strobe have to coincide in one cycle. The bench provokes this with both saturated codes and with their neighbours 0x1FFFE and 0x20001, and checks that the flag appears only in the valid cycle and only for the two saturated codes. In a second case, the end of a read falls together with a shared line that stays low. The converter model holds the line low after the re-arm pulse, and the bench checks that no serial clock edge or strobe follows until the line has gone high and then falls again.

// File: rtl/bridge_adc_pkg.sv
package bridge_adc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BIT_HI,
    ST_BIT_LO,
    ST_TAIL_HI,
    ST_TAIL_LO
  } rd_state_e;
endpackage

// File: rtl/bridge_adc_sync.sv
module bridge_adc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // idle level of the shared line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/bridge_adc_ready_det.sv
module bridge_adc_ready_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic idle_i,
  input  logic enable_i,
  output logic start_o
);
  logic armed_q;

  // armed only by a high level seen while idle and powered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= idle_i & enable_i & line_i;
  end

  assign start_o = idle_i & enable_i & armed_q & ~line_i;

  assert_start_needs_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(line_i) && $past(idle_i) && $past(enable_i)));
endmodule

// File: rtl/bridge_adc_engine.sv
module bridge_adc_engine
  import bridge_adc_pkg::*;
#(
  parameter int NBITS     = 18,
  parameter int HALF_CLKS = 2   // must be >= 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             line_i,
  output logic             idle_o,
  output logic             sclk_o,
  output logic [NBITS-1:0] result_o,
  output logic             valid_o
);
  localparam int CW = $clog2(HALF_CLKS + 1);
  localparam int BW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(HALF_CLKS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

  rd_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [BW-1:0]    bits_q;
  logic [NBITS-1:0] shreg_q;
  logic [NBITS-1:0] result_q;
  logic             sclk_q;
  logic             valid_q;
  logic             half_done;

  assign half_done = (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bits_q   <= '0;
      shreg_q  <= '0;
      result_q <= '0;
      sclk_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_BIT_HI;
            sclk_q  <= 1'b1;
            cnt_q   <= '0;
            bits_q  <= '0;
          end
        end
        ST_BIT_HI: begin
          if (half_done) begin
            state_q <= ST_BIT_LO;
            sclk_q  <= 1'b0;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_BIT_LO: begin
          if (half_done) begin
            // sample at end of low phase: line settled since the rising edge
            shreg_q <= {shreg_q[NBITS-2:0], line_i};
            sclk_q  <= 1'b1;
            cnt_q   <= '0;
            if (bits_q == LAST_BIT) state_q <= ST_TAIL_HI;
            else begin
              bits_q  <= bits_q + 1'b1;
              state_q <= ST_BIT_HI;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_TAIL_HI: begin
          if (half_done) begin
            state_q <= ST_TAIL_LO;
            sclk_q  <= 1'b0;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_TAIL_LO: begin
          if (half_done) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            result_q <= shreg_q;
            valid_q  <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign sclk_o   = sclk_q;
  assign result_o = result_q;
  assign valid_o  = valid_q;

  assert_sclk_min_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |=> sclk_q);
  assert_sclk_min_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_q) |=> !sclk_q);
  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_valid_at_rest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (idle_o && !sclk_q));
  assert_bit_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_q < BW'(NBITS));
  assert_result_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(result_q));
endmodule

// File: rtl/bridge_adc_fs.sv
module bridge_adc_fs #(
  parameter int NBITS = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBITS-1:0] word_i,
  input  logic             valid_i,
  output logic             flag_o
);
  localparam logic [NBITS-1:0] POS_FS = {1'b0, {(NBITS-1){1'b1}}};
  localparam logic [NBITS-1:0] NEG_FS = {1'b1, {(NBITS-1){1'b0}}};

  assign flag_o = valid_i & ((word_i == POS_FS) | (word_i == NEG_FS));

  assert_flag_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> valid_i);
endmodule

// File: rtl/bridge_adc_rx.sv
module bridge_adc_rx #(
  parameter int NBITS       = 18,
  parameter int HALF_CLKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rdy_dat_i,
  input  logic             run_en_i,
  input  logic             fast_rate_i,
  output logic             sclk_o,
  output logic             pwr_o,
  output logic             rate_o,
  output logic [NBITS-1:0] result_o,
  output logic             result_valid_o,
  output logic             full_scale_o
);
  logic line_s, idle, start, pwr_q, rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= 1'b0;
      rate_q <= 1'b0;
    end else begin
      pwr_q  <= run_en_i;
      rate_q <= fast_rate_i;
    end
  end

  assign pwr_o  = pwr_q;
  assign rate_o = rate_q;

  bridge_adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rdy_dat_i),
    .q_o   (line_s)
  );

  bridge_adc_ready_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_s),
    .idle_i  (idle),
    .enable_i(pwr_q),
    .start_o (start)
  );

  bridge_adc_engine #(.NBITS(NBITS), .HALF_CLKS(HALF_CLKS)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .line_i  (line_s),
    .idle_o  (idle),
    .sclk_o  (sclk_o),
    .result_o(result_o),
    .valid_o (result_valid_o)
  );

  bridge_adc_fs #(.NBITS(NBITS)) u_fs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (result_o),
    .valid_i(result_valid_o),
    .flag_o (full_scale_o)
  );

  assert_no_read_asleep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_q && idle) |=> idle);
endmodule

// File: tb/bridge_adc_rx_tb.sv
`timescale 1ns/1ps
module bridge_adc_rx_tb;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic run_en = 1'b0;
  logic fast = 1'b0;
  logic sclk, pwr, rate, valid, fs;
  logic [17:0] result;

  always #5 clk = ~clk;

  bridge_adc_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rdy_dat_i(line), .run_en_i(run_en),
    .fast_rate_i(fast), .sclk_o(sclk), .pwr_o(pwr), .rate_o(rate),
    .result_o(result), .result_valid_o(valid), .full_scale_o(fs)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model
  logic [17:0] conv_word = '0;
  int  edge_k = 0;
  bit  conv_active = 0;
  bit  hold_low = 0;
  int  rise_cnt = 0;

  always @(posedge sclk) begin
    rise_cnt++;
    if (conv_active) begin
      if (edge_k < 18) line = conv_word[17-edge_k];
      else begin
        line = hold_low ? 1'b0 : 1'b1;
        conv_active = 0;
      end
      edge_k++;
    end
  end

  // observers, sampled away from the active edge
  int  valid_cnt = 0, dbl_valid = 0, fs_stray = 0;
  logic [17:0] last_res = '0;
  bit  last_fs = 0, prev_valid = 0, prev_sclk = 0;
  int  run_len = 0, min_hi = 1000, min_lo = 1000;
  int  cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (valid) begin
        valid_cnt++;
        last_res = result;
        last_fs  = fs;
        if (prev_valid) dbl_valid++;
      end
      if (fs && !valid) fs_stray++;
      prev_valid = valid;
      if (sclk == prev_sclk) run_len++;
      else begin
        if (prev_sclk) begin if (run_len < min_hi) min_hi = run_len; end
        else if (run_len < min_lo) min_lo = run_len;
        run_len = 1;
        prev_sclk = sclk;
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [17:0] w, input bit exp_fs, input string tag);
    int v0, r0, t;
    wait_cyc(6);
    v0 = valid_cnt;
    r0 = rise_cnt;
    conv_word = w;
    edge_k = 0;
    conv_active = 1;
    line = 1'b0;
    t = 0;
    while (valid_cnt == v0 && t < 2000) begin wait_cyc(1); t++; end
    chk(valid_cnt == v0 + 1, "R5", {tag, " one strobe"}, valid_cnt - v0, 1);
    chk(last_res == w, "R3", {tag, " result bits"}, last_res, w);
    chk(rise_cnt - r0 == 19, "R3", {tag, " rising edges"}, rise_cnt - r0, 19);
    chk(last_fs == exp_fs, "R6", {tag, " full-scale flag"}, last_fs, exp_fs);
    wait_cyc(3);
    chk(result == w, "R5", {tag, " result held"}, result, w);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    chk(sclk == 0, "R1", "sclk at reset", sclk, 0);
    chk(valid == 0 && fs == 0, "R1", "strobes at reset", {valid, fs}, 0);
    chk(result == 0, "R1", "result at reset", result, 0);
    chk(pwr == 0 && rate == 0, "R1", "pins at reset", {pwr, rate}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_config;
    run_en = 1; fast = 0;
    wait_cyc(2);
    chk(pwr == 1, "R7", "power follows enable", pwr, 1);
    chk(rate == 0, "R8", "slow rate low", rate, 0);
    fast = 1;
    wait_cyc(2);
    chk(rate == 1, "R8", "fast rate high", rate, 1);
    fast = 0;
    wait_cyc(2);
    chk(rate == 0, "R8", "back to slow", rate, 0);
  endtask

  task automatic t_reads;
    do_read(18'h2A5C3, 0, "mixed");
    do_read(18'h1FFFF, 1, "pos fs");
    do_read(18'h20000, 1, "neg fs");
    do_read(18'h1FFFE, 0, "below pos fs");
    do_read(18'h20001, 0, "above neg fs");
    do_read(18'h00000, 0, "zero");
    do_read(18'h3FFFF, 0, "minus one");
    chk(fs_stray == 0, "R6", "flag outside strobe", fs_stray, 0);
    chk(dbl_valid == 0, "R5", "strobe width", dbl_valid, 0);
  endtask

  task automatic t_phase;
    chk(min_hi >= HALF, "R4", "min sclk high", min_hi, HALF);
    chk(min_lo >= HALF, "R4", "min sclk low", min_lo, HALF);
  endtask

  task automatic t_stale;
    int v0, r0;
    hold_low = 1;
    do_read(18'h15A5A, 0, "stale setup");
    hold_low = 0;
    v0 = valid_cnt; r0 = rise_cnt;
    wait_cyc(60);
    chk(rise_cnt == r0, "R2", "no clock on stale low", rise_cnt - r0, 0);
    chk(valid_cnt == v0, "R2", "no strobe on stale low", valid_cnt - v0, 0);
    line = 1'b1;
    wait_cyc(10);
    chk(rise_cnt == r0, "R2", "no clock on high", rise_cnt - r0, 0);
    do_read(18'h0F0F0, 0, "after rearm");
  endtask

  task automatic t_sleep;
    int v0, r0;
    run_en = 0;
    wait_cyc(4);
    chk(pwr == 0, "R7", "power low", pwr, 0);
    v0 = valid_cnt; r0 = rise_cnt;
    line = 1'b0;
    wait_cyc(60);
    chk(rise_cnt == r0, "R7", "no read asleep", rise_cnt - r0, 0);
    chk(valid_cnt == v0, "R7", "no strobe asleep", valid_cnt - v0, 0);
    run_en = 1;
    wait_cyc(20);
    chk(rise_cnt == r0, "R2", "low at wake ignored", rise_cnt - r0, 0);
    line = 1'b1;
    do_read(18'h12345, 0, "after wake");
  endtask

  initial begin
    t_reset();
    t_config();
    t_reads();
    t_phase();
    t_stale();
    t_sleep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule